// File: doc/BRIEF.md
# Frame Min-Max Normalizer

This block rescales a finite frame of unsigned samples so that the frame's smallest value becomes 0 and its largest becomes 255. Samples come in one per valid/ready transfer, and a last flag marks the end of the frame. While the frame arrives, every sample is written into an internal buffer and a running minimum and maximum are kept up to date.

When the last sample has been taken, the block replays the buffer in arrival order. For each stored sample it computes floor((x - min) * 255 / (max - min)) and offers the result on a valid/ready output. The final result carries its own last flag. The division by the data-dependent span is done by a restoring shift-subtract divider that makes one quotient bit per clock.

The input is closed from the end of a frame until the last result of that frame has been handed off. Samples beyond the buffer depth are dropped, and a flag reports that this happened.

Top module: `range_normalizer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and overflow is 0.
- R2: in_ready is 1 only while a frame is being collected. It is 0 from the cycle after the sample flagged last is accepted until the cycle after the final result of that frame is handed off, and never 1 while out_valid is 1.
- R3: Only the first DEPTH samples of a frame are stored and used for the extremes; later samples are accepted and discarded. overflow goes to 1 on the clock that discards a sample and stays 1 until the first sample of the next frame is accepted.
- R4: Each result equals floor((x - min) * 255 / (max - min)) over the stored samples, on 8 bits.
- R5: A stored sample equal to the frame minimum gives 0, and one equal to the frame maximum gives 255.
- R6: When all stored samples are equal, including a frame of one sample, every result is 0.
- R7: One result is produced per stored sample, in arrival order. out_last is 1 only together with out_valid, on the final result.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R9: After a handoff, or after the last input sample, out_valid rises DATA_W + 10 clocks later when the span is nonzero (one clock per quotient bit plus two), and 1 clock later when the span is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts an input sample |
| in_data | input | DATA_W | Unsigned input sample |
| in_last | input | 1 | Marks the final sample of a frame |
| out_valid | output | 1 | Normalized result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | OUT_W | Normalized result, 0 to 255 |
| out_last | output | 1 | Marks the final result of a frame |
| overflow | output | 1 | A sample of the current or last frame was dropped |

## Verification
The bench goes after the extreme cases of the span. A full-scale frame from 0 to 4095 catches a product or quotient that is truncated, because the maximum would then come out below 255. A constant frame and a single-sample frame catch a design that divides by zero instead of forcing 0. A frame of DEPTH + 3 samples checks the following: a design that stores past the end, counts discarded samples in the extremes, or clears the flag too early gives wrong values, a wrong out_last position, or a missing flag. Stalled output and measured result latency expose results that change under back-pressure and a divider whose iteration count is wrong.

// File: rtl/norm_pkg.sv
package norm_pkg;
   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_LOAD    = 2'd1,
      ST_DIVIDE  = 2'd2,
      ST_EMIT    = 2'd3
   } norm_state_e;
endpackage

// File: rtl/frame_store.sv
module frame_store #(
   parameter int W     = 12,
   parameter int DEPTH = 64,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/extreme_tracker.sv
module extreme_tracker #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] sample,
   output logic [W-1:0] min_o,
   output logic [W-1:0] max_o
);
   logic [W-1:0] min_q, max_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_q <= '1;
         max_q <= '0;
      end else if (clr) begin
         min_q <= '1;
         max_q <= '0;
      end else if (upd) begin
         if (sample < min_q) min_q <= sample;
         if (sample > max_q) max_q <= sample;
      end
   end

   assign min_o = min_q;
   assign max_o = max_q;
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
   parameter int NUM_W  = 20,
   parameter int DEN_W  = 12,
   parameter int QOUT_W = 8,
   localparam int CNT_W = $clog2(NUM_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NUM_W-1:0]  num,
   input  logic [DEN_W-1:0]  den,
   output logic              done,
   output logic [QOUT_W-1:0] quot
);
   logic [DEN_W-1:0] rem_q, den_q;
   logic [NUM_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, done_q;
   logic [DEN_W:0]   shifted, trial;
   logic             fits;

   always_comb begin
      shifted = {rem_q, quo_q[NUM_W-1]};
      trial   = shifted - {1'b0, den_q};
      fits    = shifted >= {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         den_q  <= den;
         quo_q  <= num;
         cnt_q  <= CNT_W'(NUM_W);
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (busy_q) begin
         rem_q <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
         quo_q <= {quo_q[NUM_W-2:0], fits};
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign quot = quo_q[QOUT_W-1:0];
endmodule

// File: rtl/range_normalizer.sv
module range_normalizer
   import norm_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64,
   parameter int OUT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_last,
   output logic              overflow
);
   localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW      = $clog2(DEPTH + 1);
   localparam int NUM_W   = DATA_W + OUT_W;
   localparam int OUT_MAX = (1 << OUT_W) - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $fatal(1, "DATA_W must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $fatal(1, "DEPTH must be at least 2");
      end
      if (OUT_W < 1 || OUT_W > 16) begin : g_bad_out
         $fatal(1, "OUT_W must lie in 1..16");
      end
   endgenerate

   norm_state_e       state_q;
   logic [CW-1:0]     wr_cnt_q;
   logic [AW-1:0]     rd_idx_q;
   logic [OUT_W-1:0]  res_q;
   logic              ovf_q;

   logic              accept, room, store_en, is_last, frame_done;
   logic [DATA_W-1:0] rd_data, min_v, max_v, span, diff;
   logic [NUM_W-1:0]  scaled;
   logic              div_start, div_done;
   logic [OUT_W-1:0]  div_quot;

   assign in_ready   = (state_q == ST_COLLECT);
   assign accept     = in_valid && in_ready;
   assign room       = (wr_cnt_q < CW'(DEPTH));
   assign store_en   = accept && room;
   assign is_last    = ((CW'(rd_idx_q) + CW'(1)) == wr_cnt_q);
   assign frame_done = (state_q == ST_EMIT) && out_ready && is_last;

   frame_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (store_en),
      .waddr (AW'(wr_cnt_q)),
      .wdata (in_data),
      .raddr (rd_idx_q),
      .rdata (rd_data)
   );

   extreme_tracker #(.W(DATA_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frame_done),
      .upd    (store_en),
      .sample (in_data),
      .min_o  (min_v),
      .max_o  (max_v)
   );

   assign span      = max_v - min_v;
   assign diff      = rd_data - min_v;
   assign scaled    = NUM_W'(diff) * NUM_W'(OUT_MAX);
   assign div_start = (state_q == ST_LOAD) && (span != '0);

   seq_divider #(.NUM_W(NUM_W), .DEN_W(DATA_W), .QOUT_W(OUT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (scaled),
      .den   (span),
      .done  (div_done),
      .quot  (div_quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_COLLECT;
         wr_cnt_q <= '0;
         rd_idx_q <= '0;
         res_q    <= '0;
         ovf_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_COLLECT: begin
               if (accept) begin
                  if (wr_cnt_q == '0) ovf_q <= 1'b0;
                  if (room) wr_cnt_q <= wr_cnt_q + CW'(1);
                  else      ovf_q    <= 1'b1;
                  if (in_last) begin
                     rd_idx_q <= '0;
                     state_q  <= ST_LOAD;
                  end
               end
            end
            ST_LOAD: begin
               if (span == '0) begin
                  res_q   <= '0;
                  state_q <= ST_EMIT;
               end else begin
                  state_q <= ST_DIVIDE;
               end
            end
            ST_DIVIDE: begin
               if (div_done) begin
                  res_q   <= div_quot;
                  state_q <= ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (out_ready) begin
                  if (is_last) begin
                     wr_cnt_q <= '0;
                     state_q  <= ST_COLLECT;
                  end else begin
                     rd_idx_q <= rd_idx_q + AW'(1);
                     state_q  <= ST_LOAD;
                  end
               end
            end
            default: state_q <= ST_COLLECT;
         endcase
      end
   end

   assign out_valid = (state_q == ST_EMIT);
   assign out_data  = res_q;
   assign out_last  = out_valid && is_last;
   assign overflow  = ovf_q;
endmodule

// File: rtl/range_normalizer_chk.sv
module range_normalizer_chk #(
   parameter int OUT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_data,
   input logic             out_last,
   input logic             overflow
);
   p_ready_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready)
      else $error("R2: input open while a result is offered");

   p_overflow_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(in_valid && in_ready))
      else $error("R3: overflow raised without an accepted sample");

   p_last_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid)
      else $error("R7: out_last without out_valid");

   p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
      else $error("R8: result changed under back-pressure");
endmodule

bind range_normalizer range_normalizer_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/range_normalizer_bench.sv
module range_normalizer_bench;
   localparam int DATA_W = 12;
   localparam int DEPTH  = 64;
   localparam int OUT_W  = 8;
   localparam int LAT    = DATA_W + OUT_W + 2;
   localparam int NV     = 11;
   // {last, sample}
   localparam logic [DATA_W:0] VEC [NV] = '{
      {1'b0, 12'd100}, {1'b0, 12'd400}, {1'b0, 12'd250}, {1'b1, 12'd1000},
      {1'b0, 12'd4095}, {1'b0, 12'd0}, {1'b1, 12'd2048},
      {1'b0, 12'd7}, {1'b0, 12'd7}, {1'b1, 12'd7},
      {1'b1, 12'd5}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_last = 1'b0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [OUT_W-1:0]  out_data;
   logic              out_last;
   logic              overflow;

   int checks = 0;
   int errors = 0;
   int fbuf [DEPTH];
   int fcnt = 0;

   always #10 clk = ~clk;

   range_normalizer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OUT_W(OUT_W)) u_range_normalizer (
      .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_last,
      .out_valid, .out_ready, .out_data, .out_last, .overflow
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int expect_val(input int x, input int mn, input int mx);
      if (mx == mn) return 0;
      return ((x - mn) * 255) / (mx - mn);
   endfunction

   // starts and ends at a falling edge
   task automatic send(input int d, input bit l);
      in_valid = 1'b1;
      in_data  = DATA_W'(d);
      in_last  = l;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic recv(input int stall, output int d, output bit l, output int wait_n);
      wait_n = 0;
      while (!out_valid) begin
         @(negedge clk);
         wait_n++;
      end
      d = int'(out_data);
      l = out_last;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         check(out_valid && int'(out_data) == d && out_last == l, "R8 stall hold",
               int'(out_data), d);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic drain_frame(input int stall);
      int mn, mx, d, w, e;
      bit l;
      mn = fbuf[0];
      mx = fbuf[0];
      for (int i = 1; i < fcnt; i++) begin
         if (fbuf[i] < mn) mn = fbuf[i];
         if (fbuf[i] > mx) mx = fbuf[i];
      end
      check(!in_ready, "R2 input closed after last", int'(in_ready), 0);
      for (int i = 0; i < fcnt; i++) begin
         recv((i == 1) ? stall : 0, d, l, w);
         e = expect_val(fbuf[i], mn, mx);
         if (mn == mx)            check(d == e, "R6 flat frame", d, e);
         else if (fbuf[i] == mn)  check(d == 0, "R5 minimum", d, 0);
         else if (fbuf[i] == mx)  check(d == 255, "R5 maximum", d, 255);
         else                     check(d == e, "R4 scaled value", d, e);
         check(l == (i == fcnt - 1), "R7 last flag", int'(l), int'(i == fcnt - 1));
         check(w == ((mn == mx) ? 1 : LAT), "R9 latency", w, (mn == mx) ? 1 : LAT);
         if (i < fcnt - 1)
            check(!in_ready, "R2 closed during output", int'(in_ready), 0);
      end
      check(in_ready, "R2 reopened after final handoff", int'(in_ready), 1);
      fcnt = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(in_ready && !out_valid && !overflow, "R1 reset state",
            {29'd0, in_ready, out_valid, overflow}, 4);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready && !out_valid && !overflow, "R1 after release",
            {29'd0, in_ready, out_valid, overflow}, 4);

      // vector table: frames of various shapes
      for (int v = 0; v < NV; v++) begin
         fbuf[fcnt] = int'(VEC[v][DATA_W-1:0]);
         fcnt++;
         send(int'(VEC[v][DATA_W-1:0]), VEC[v][DATA_W]);
         if (VEC[v][DATA_W]) drain_frame((v == 3) ? 3 : 0);
      end

      // R3: frame longer than the buffer
      for (int i = 0; i < DEPTH + 3; i++) begin
         if (i < DEPTH) begin
            fbuf[i] = (i * 61) % 4096;
            fcnt++;
         end
         send((i * 61) % 4096 + ((i >= DEPTH) ? 1 : 0), i == DEPTH + 2);
         if (i == DEPTH - 1) check(!overflow, "R3 no flag at depth", int'(overflow), 0);
         if (i == DEPTH)     check(overflow, "R3 flag on drop", int'(overflow), 1);
      end
      drain_frame(2);
      check(overflow, "R3 flag held after frame", int'(overflow), 1);

      // next frame clears the flag on its first sample
      fbuf[0] = 5;
      fcnt = 1;
      send(5, 1'b1);
      check(!overflow, "R3 flag cleared by new frame", int'(overflow), 0);
      drain_frame(0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule